// File: doc/BRIEF.md
# SRAM Sleep-Mode Sequencer

This block sits between the asynchronous low-power request pin of a synchronous SRAM and its access front end. It brings the pin into the clock domain through a two-flop synchroniser. It then steps through a fixed two-clock entry phase, a sleep state, a fixed two-clock exit phase and a recovery window of programmable length. From the moment entry begins until recovery ends it inhibits every access. Chip-select and address-strobe activity in that period is ignored and reported as a protocol violation. An access still pending when entry begins is reported as discarded.

The array contents are assumed to be retained by the storage itself. The block only guarantees that no write enable reaches the array while it is inhibited. Power switching is handled elsewhere.

Top module: `sleep_seq`

## Requirements
- R1: The sleep pin passes through a two-flop synchroniser. If the pin is high at clock edge k, `inhibit` first reads high after edge k+2, and not before.
- R2: Entry takes exactly two clocks. The state stays in the entry phase for two edges, and `asleep` reads high after the second of them.
- R3: While asleep, a low level on the synchronised pin starts a two-clock exit phase. `asleep` reads low from the first exit cycle onward.
- R4: After the exit phase, a recovery window of exactly RECOV_CYCLES clocks follows. `inhibit` then returns low.
- R5: `inhibit` is high in the entry, sleep, exit and recovery states and low only when awake. `asleep` is high only in the sleep state.
- R6: While awake, `acc_go` is `chip_sel AND (strb_a OR strb_b)`, computed combinationally.
- R7: `array_we` equals `acc_go AND wr_req`. It is therefore never high while `inhibit` is high.
- R8: `pend_dropped` is a one-cycle pulse. It appears in the first entry cycle when `access_pend` was high on the edge at which entry began.
- R9: Any of `chip_sel`, `strb_a` or `strb_b` high while inhibited is ignored, so `acc_go` stays low. It raises `proto_viol` for exactly the following cycle.
- R10: Synchronous active-low reset puts the block in the awake state with `asleep`, `inhibit`, `pend_dropped` and `proto_viol` low.
- R11: Entry and recovery always run to completion. A pin drop during entry still reaches sleep and then exits. A pin rise during recovery is acted on only after the block is awake again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_pin | input | 1 | Asynchronous sleep request, high requests sleep |
| chip_sel | input | 1 | Combined chip enable, high when selected |
| strb_a | input | 1 | First address strobe, high active |
| strb_b | input | 1 | Second address strobe, high active |
| wr_req | input | 1 | Write qualifier for the current access |
| access_pend | input | 1 | An access is in flight in the front end |
| acc_go | output | 1 | Access accepted this cycle |
| array_we | output | 1 | Write enable toward the array |
| asleep | output | 1 | Sleep state active |
| inhibit | output | 1 | Accesses blocked |
| pend_dropped | output | 1 | Pending access discarded at entry |
| proto_viol | output | 1 | Enable or strobe seen while inhibited |

## Verification
The hardest situations to reach from the ports are the overlapping ones. One is a pin that falls while entry is still in progress. Another is a pin that rises again inside the recovery window. A third is strobe activity that lands in the last recovery cycle and then the first awake cycle.

The stimulus reaches these by placing pin edges a counted number of clocks after earlier edges, using the synchroniser latency. It sweeps strobe bursts across every phase. A behavioural model, driven by the same pins, is compared with every output on every clock.

// File: rtl/sleep_seq_pkg.sv
// Shared types for the sleep-mode sequencer.
package sleep_seq_pkg;
    typedef enum logic [2:0] {
        ST_AWAKE    = 3'd0,
        ST_ENTERING = 3'd1,
        ST_ASLEEP   = 3'd2,
        ST_EXITING  = 3'd3,
        ST_RECOVERY = 3'd4
    } sleep_state_t;
endpackage

// File: rtl/sleep_sync.sv
// Multi-flop synchroniser for one asynchronous level input.
// Assumes STAGES >= 2. Reset clears all stages to the awake level.
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/phase_timer.sv
// Counts clocks while enabled and clears when disabled.
// done is high in the LIMIT-th consecutive enabled cycle. Assumes LIMIT >= 1.
module phase_timer #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Advance while enabled, wrap at the last count, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (done)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == LAST);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/sleep_seq.sv
// Sleep-mode sequencer: synchronises the sleep pin and runs the
// awake, entering, asleep, exiting and recovery phases. It gates access
// strobes and array writes, and flags dropped accesses and strobe activity
// while inhibited. Assumes array retention is provided by the storage itself.
module sleep_seq
    import sleep_seq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int PHASE_CYCLES = 2,
    parameter int RECOV_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_pin,
    input  logic chip_sel,
    input  logic strb_a,
    input  logic strb_b,
    input  logic wr_req,
    input  logic access_pend,
    output logic acc_go,
    output logic array_we,
    output logic asleep,
    output logic inhibit,
    output logic pend_dropped,
    output logic proto_viol
);
    sleep_state_t state, state_nx;
    logic req_s, phase_en, phase_done, rec_en, rec_done, activity;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sleep_pin), .sync_out(req_s)
    );

    assign phase_en = (state == ST_ENTERING) || (state == ST_EXITING);
    assign rec_en   = (state == ST_RECOVERY);

    phase_timer #(.LIMIT(PHASE_CYCLES)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(phase_en), .done(phase_done)
    );

    phase_timer #(.LIMIT(RECOV_CYCLES)) u_recov (
        .clk(clk), .rst_n(rst_n), .en(rec_en), .done(rec_done)
    );

    // Pick the next phase; entry and recovery always run to completion.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AWAKE:    if (req_s)      state_nx = ST_ENTERING;
            ST_ENTERING: if (phase_done) state_nx = ST_ASLEEP;
            ST_ASLEEP:   if (!req_s)     state_nx = ST_EXITING;
            ST_EXITING:  if (phase_done) state_nx = ST_RECOVERY;
            ST_RECOVERY: if (rec_done)   state_nx = ST_AWAKE;
            default:                     state_nx = ST_AWAKE;
        endcase
    end

    // Hold the phase state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= state_nx;
    end

    assign activity = chip_sel || strb_a || strb_b;
    assign inhibit  = (state != ST_AWAKE);
    assign asleep   = (state == ST_ASLEEP);
    assign acc_go   = !inhibit && chip_sel && (strb_a || strb_b);
    assign array_we = acc_go && wr_req;

    // Register the one-cycle event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_dropped <= 1'b0;
            proto_viol   <= 1'b0;
        end else begin
            pend_dropped <= (state == ST_AWAKE) && req_s && access_pend;
            proto_viol   <= inhibit && activity;
        end
    end

    // R2
    entry_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> ($past(state == ST_ENTERING) && $past(state == ST_ENTERING, 2)));

    // R3
    exit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVERY && $past(state) != ST_RECOVERY)
            |-> ($past(state == ST_EXITING) && $past(state == ST_EXITING, 2)));

    // R4
    recov_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVERY && rec_done) |=> !inhibit);

    // R1
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && !req_s) |=> !inhibit);

    // R9
    viol_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && activity) |=> proto_viol);

    // R8
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_dropped |-> (state == ST_ENTERING && $past(access_pend)));
endmodule

// File: tb/sleep_seq_tb.sv
module sleep_seq_tb;
    localparam int RC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_pin = 1'b0, chip_sel = 1'b0, strb_a = 1'b0, strb_b = 1'b0;
    logic wr_req = 1'b0, access_pend = 1'b0;
    logic acc_go, array_we, asleep, inhibit, pend_dropped, proto_viol;

    int checks = 0, errors = 0, cycles = 0;
    bit started = 1'b0;

    always #5 clk = ~clk;

    sleep_seq #(.RECOV_CYCLES(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .chip_sel(chip_sel),
        .strb_a(strb_a), .strb_b(strb_b), .wr_req(wr_req), .access_pend(access_pend),
        .acc_go(acc_go), .array_we(array_we), .asleep(asleep), .inhibit(inhibit),
        .pend_dropped(pend_dropped), .proto_viol(proto_viol)
    );

    // Behavioural model: 0 awake, 1 entering, 2 asleep, 3 exiting, 4 recovery.
    int m_st = 0, m_ph = 0, m_rc = 0;
    bit m_s1 = 0, m_s2 = 0, m_pd = 0, m_pv = 0;

    always @(posedge clk) begin
        bit act;
        act = chip_sel | strb_a | strb_b;
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_rc = 0; m_s1 = 0; m_s2 = 0; m_pd = 0; m_pv = 0;
        end else begin
            m_pd = (m_st == 0) && m_s2 && access_pend;
            m_pv = (m_st != 0) && act;
            case (m_st)
                0: if (m_s2) begin m_st = 1; m_ph = 0; end
                1: if (m_ph == 1) m_st = 2; else m_ph++;
                2: if (!m_s2) begin m_st = 3; m_ph = 0; end
                3: if (m_ph == 1) begin m_st = 4; m_rc = 0; end else m_ph++;
                default: if (m_rc == RC - 1) m_st = 0; else m_rc++;
            endcase
            m_s2 = m_s1;
            m_s1 = sleep_pin;
        end
        started = 1'b1;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model once per cycle, mid low phase.
    always @(negedge clk) begin
        #3;
        if (started) begin
            bit eg;
            eg = (m_st == 0) && chip_sel && (strb_a || strb_b);
            chk("R2 asleep",       asleep,       m_st == 2);
            chk("R5 inhibit",      inhibit,      m_st != 0);
            chk("R6 acc_go",       acc_go,       eg);
            chk("R7 array_we",     array_we,     eg && wr_req);
            chk("R8 pend_dropped", pend_dropped, m_pd);
            chk("R9 proto_viol",   proto_viol,   m_pv);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobes(input logic cs, input logic a, input logic b, input logic w);
        chip_sel = cs; strb_a = a; strb_b = b; wr_req = w;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        #3;
        // R10 reset state
        chk("R10 inhibit", inhibit, 1'b0);
        chk("R10 asleep", asleep, 1'b0);
        chk("R10 pend_dropped", pend_dropped, 1'b0);
        chk("R10 proto_viol", proto_viol, 1'b0);
        tick(1); rst_n = 1'b1;
        tick(2);

        // R6 R7 awake access patterns
        strobes(1, 1, 0, 1); tick(1);
        strobes(1, 0, 1, 0); tick(1);
        strobes(0, 1, 1, 1); tick(1);
        strobes(1, 0, 0, 1); tick(1);
        strobes(0, 0, 0, 0); tick(1);

        // R1 R2 R8 entry with a pending access
        access_pend = 1'b1; sleep_pin = 1'b1;
        tick(2); #3; chk("R1 inhibit before sync", inhibit, 1'b0);
        tick(1); #3; chk("R1 inhibit after sync", inhibit, 1'b1);
        chk("R8 dropped pulse", pend_dropped, 1'b1);
        access_pend = 1'b0;
        tick(1); #3; chk("R2 not yet asleep", asleep, 1'b0);
        tick(1); #3; chk("R2 asleep", asleep, 1'b1);

        // R9 R7 activity while asleep is ignored
        tick(1); strobes(1, 1, 1, 1);
        tick(1); #3; chk("R9 acc_go ignored", acc_go, 1'b0);
        chk("R7 no write asleep", array_we, 1'b0);
        chk("R9 viol raised", proto_viol, 1'b1);
        strobes(0, 0, 0, 0);
        tick(3);

        // R3 R4 exit and recovery timing
        sleep_pin = 1'b0;
        tick(2); #3; chk("R3 still asleep", asleep, 1'b1);
        tick(1); #3; chk("R3 exit started", asleep, 1'b0);
        tick(2); strobes(1, 0, 1, 1);   // activity inside recovery
        tick(1); strobes(0, 0, 0, 0);
        tick(RC - 2); #3; chk("R4 last recovery cycle", inhibit, 1'b1);
        tick(1); #3; chk("R4 awake after recovery", inhibit, 1'b0);
        tick(3);

        // R11 pin drop during entry still reaches sleep, then exits
        sleep_pin = 1'b1;
        tick(3); sleep_pin = 1'b0;
        tick(2); #3; chk("R11 reaches sleep", asleep, 1'b1);
        tick(1); #3; chk("R11 exits after", asleep, 1'b0);
        tick(4);
        // R11 re-request during recovery, strobe sweep across all phases
        sleep_pin = 1'b1;
        for (int i = 0; i < 3 * RC + 20; i++) begin
            if (i == 4) sleep_pin = 1'b0;
            strobes(i[0], i[1], i[2], i[3]);
            access_pend = i[2];
            tick(1);
        end
        strobes(0, 0, 0, 0); access_pend = 1'b0;
        tick(2 * RC + 10);

        // Sleep with inputs quiet, then release.
        sleep_pin = 1'b1; tick(8); sleep_pin = 1'b0; tick(RC + 8);
        tick(1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule